// File: doc/BRIEF.md
# Real-Time Clock with Delayed-Commit Register Writes

This peripheral keeps time as a 64-bit value: a whole-seconds word and a fractional word that advances by one on every prescaler tick. It also holds a two-word alarm compare value and control, status and interrupt-enable registers, all behind a plain 32-bit register port. Every register write is held for a fixed number of clock cycles before it takes effect, which stands in for a slow timekeeping clock domain. Status flags tell software when a write is still pending, when it has landed and when it has been rejected.

Software is expected to issue a write and then poll status until either the completion flag or the error flag is set before it accesses the block again. Out of reset the block is marked not-valid and refuses every write except one to status. Software must first clear that condition, then load the seconds word and set the counter enable. The counter does not move until both have happened. Sticky flags are cleared by writing ones to them, and a single registered interrupt line reflects the flags that have been enabled.

Top module: `rtc_wcommit`

## Requirements
- R1: Registers sit at word index `addr_i`: 0 seconds, 1 fraction, 2 alarm upper, 3 alarm lower, 4 control, 5 status, 6 interrupt enable. After reset the status register reads 0x202 (bit 1 not-valid, bit 9 write-next), alarm upper reads 0xFFFFFFFF, every other register reads 0, and `irq_o` is low. `rdata_o` is 0 whenever `rd_i` is low.
- R2: While not-valid is set, a committed write to any register other than status leaves that register unchanged, sets write-error (status bit 7) and leaves write-complete (status bit 8) clear.
- R3: A committed status write clears not-valid only when data bits 0 and 1 are both one. Data bits 4 and 7 clear the alarm flag and the write-error flag. Every accepted write that is not refused sets write-complete when it commits, except a status write whose data bit 8 is one.
- R4: An accepted write commits on the 4th clock edge after the edge that accepted it. From the accept edge until the commit edge, status bit 10 (busy) reads 1, bit 9 (write-next) reads 0, and write-complete reads 0.
- R5: A write that arrives while busy is dropped and sets write-error. The pending write still commits with its own data.
- R6: While control bit 3 is set and the seconds word has been written since reset, each cycle with `tick_i` high increments the fraction. When the fraction wraps from 0xFFFFFFFF to 0, the seconds word increments.
- R7: The counter does not advance until the seconds word has been written, even with control bit 3 set and a fraction write already made.
- R8: With control bit 3 clear, ticks change neither word.
- R9: The alarm flag (status bit 4) is set on the edge after {seconds, fraction} equals {alarm upper, alarm lower}. It stays set until cleared by a status write.
- R10: While alarm upper is 0xFFFFFFFF the alarm flag is never set, even when the counter equals the alarm value.
- R11: `irq_o` goes high one cycle after any of status bits 9, 8, 7 or 4 is set together with the same bit in the interrupt-enable register, and low one cycle after none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick, advances the fraction |
| addr_i | input | 3 | Register word index |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The write path is tested with single writes, back-to-back writes that collide, writes refused while not-valid, and status writes carrying different one-bit masks. Together these separate the commit latency, the dropping of a colliding write, the refusal rule and the clear-by-one behaviour. The counter is tested with a fraction preset just below wrap, with the enable on and off, and before and after the seconds word is loaded, which separates carry, halt and freeze. The alarm is tested with a matching value, with a match left behind by later ticks, and with the same match under an all-ones upper word, which separates sticky setting from the unset condition.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_SEC   = 3'd0;
  localparam logic [ADR_W-1:0] ADR_FRAC  = 3'd1;
  localparam logic [ADR_W-1:0] ADR_ALMHI = 3'd2;
  localparam logic [ADR_W-1:0] ADR_ALMLO = 3'd3;
  localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd4;
  localparam logic [ADR_W-1:0] ADR_STAT  = 3'd5;
  localparam logic [ADR_W-1:0] ADR_IEN   = 3'd6;

  localparam int B_RUN  = 3;
  localparam int B_BUSY = 10;
  localparam int B_NEXT = 9;
  localparam int B_DONE = 8;
  localparam int B_ERR  = 7;
  localparam int B_ALM  = 4;
  localparam int B_INV  = 1;
  localparam int B_SEC  = 0;

  localparam logic [31:0] IRQ_MASK = (32'd1 << B_NEXT) | (32'd1 << B_DONE) |
                                     (32'd1 << B_ERR)  | (32'd1 << B_ALM);
endpackage

// File: rtl/rtc_wr_pipe.sv
module rtc_wr_pipe #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int DELAY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          collide_o,
  output logic          commit_o,
  output logic [AW-1:0] caddr_o,
  output logic [DW-1:0] cdata_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;

  assign busy_o    = (cnt_q != '0);
  assign accept_o  = wr_i & ~busy_o;
  assign collide_o = wr_i & busy_o;
  assign commit_o  = (cnt_q == CW'(1));
  assign caddr_o   = addr_q;
  assign cdata_o   = data_q;

  always_comb begin
    cnt_n  = cnt_q;
    addr_n = addr_q;
    data_n = data_q;
    if (accept_o) begin
      cnt_n  = CW'(DELAY);
      addr_n = addr_i;
      data_n = wdata_i;
    end else if (busy_o) begin
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (accept_o) begin
        addr_q <= addr_n;
        data_q <= data_n;
      end
    end
  end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          ld_sec_i,
  input  logic          ld_frac_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [DW-1:0] sec_o,
  output logic [DW-1:0] frac_o,
  output logic          seen_o
);
  logic [DW-1:0] sec_q, sec_n, frac_q, frac_n;
  logic          seen_q, seen_n;
  logic          step;

  assign step   = tick_i & en_i & seen_q;
  assign sec_o  = sec_q;
  assign frac_o = frac_q;
  assign seen_o = seen_q;

  always_comb begin
    sec_n  = sec_q;
    frac_n = frac_q;
    seen_n = seen_q | ld_sec_i;
    if (step) begin
      frac_n = frac_q + DW'(1);
      if (&frac_q) sec_n = sec_q + DW'(1);
    end
    if (ld_frac_i) frac_n = ld_data_i;
    if (ld_sec_i)  sec_n  = ld_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sec_q  <= sec_n;
      frac_q <= frac_n;
      seen_q <= seen_n;
    end
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] ien_i,
  output logic          irq_o
);
  logic irq_q, irq_n;

  assign irq_n = |(status_i & ien_i & DW'(rtc_pkg::IRQ_MASK));
  assign irq_o = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end
endmodule

// File: rtl/rtc_wcommit.sv
module rtc_wcommit #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int DELAY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  import rtc_pkg::*;

  logic          busy, accept, collide, cmt;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;

  logic          run_q, run_n;
  logic [DW-1:0] ien_q, ien_n, almhi_q, almhi_n, almlo_q, almlo_n;
  logic          inv_q, inv_n, err_q, err_n, done_q, done_n, alm_q, alm_n;
  logic [DW-1:0] sec, frac, status_w;
  logic          seen, ok_cmt, refused, st_cmt, alarm_hit;

  rtc_wr_pipe #(.DW(DW), .AW(AW), .DELAY(DELAY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .busy_o(busy), .accept_o(accept), .collide_o(collide), .commit_o(cmt),
    .caddr_o(c_addr), .cdata_o(c_data)
  );

  assign refused = cmt & inv_q & (c_addr != AW'(ADR_STAT));
  assign ok_cmt  = cmt & ~refused;
  assign st_cmt  = ok_cmt & (c_addr == AW'(ADR_STAT));

  rtc_timebase #(.DW(DW)) u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(run_q),
    .ld_sec_i(ok_cmt & (c_addr == AW'(ADR_SEC))),
    .ld_frac_i(ok_cmt & (c_addr == AW'(ADR_FRAC))),
    .ld_data_i(c_data), .sec_o(sec), .frac_o(frac), .seen_o(seen)
  );

  assign alarm_hit = (sec == almhi_q) & (frac == almlo_q) & ~(&almhi_q);

  always_comb begin
    status_w         = '0;
    status_w[B_BUSY] = busy;
    status_w[B_NEXT] = ~busy;
    status_w[B_DONE] = done_q;
    status_w[B_ERR]  = err_q;
    status_w[B_ALM]  = alm_q;
    status_w[B_INV]  = inv_q;
  end

  always_comb begin
    run_n   = run_q;
    ien_n   = ien_q;
    almhi_n = almhi_q;
    almlo_n = almlo_q;
    inv_n   = inv_q;
    err_n   = err_q;
    done_n  = done_q;
    alm_n   = alm_q | alarm_hit;
    if (accept) done_n = 1'b0;
    if (ok_cmt) begin
      done_n = 1'b1;
      unique case (c_addr)
        AW'(ADR_ALMHI): almhi_n = c_data;
        AW'(ADR_ALMLO): almlo_n = c_data;
        AW'(ADR_CTRL):  run_n   = c_data[B_RUN];
        AW'(ADR_IEN):   ien_n   = c_data & DW'(IRQ_MASK);
        default: ;
      endcase
    end
    if (st_cmt) begin
      if (c_data[B_INV] & c_data[B_SEC]) inv_n = 1'b0;
      if (c_data[B_ERR])  err_n  = 1'b0;
      if (c_data[B_ALM])  alm_n  = 1'b0;
      if (c_data[B_DONE]) done_n = 1'b0;
    end
    if (collide | refused) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ien_q   <= '0;
      almhi_q <= '1;
      almlo_q <= '0;
      inv_q   <= 1'b1;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      alm_q   <= 1'b0;
    end else begin
      run_q   <= run_n;
      ien_q   <= ien_n;
      almhi_q <= almhi_n;
      almlo_q <= almlo_n;
      inv_q   <= inv_n;
      err_q   <= err_n;
      done_q  <= done_n;
      alm_q   <= alm_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        AW'(ADR_SEC):   rdata_o = sec;
        AW'(ADR_FRAC):  rdata_o = frac;
        AW'(ADR_ALMHI): rdata_o = almhi_q;
        AW'(ADR_ALMLO): rdata_o = almlo_q;
        AW'(ADR_CTRL):  rdata_o = DW'(run_q) << B_RUN;
        AW'(ADR_STAT):  rdata_o = status_w;
        AW'(ADR_IEN):   rdata_o = ien_q;
        default:        rdata_o = '0;
      endcase
    end
  end

  rtc_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .status_i(status_w), .ien_i(ien_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/rtc_wcommit_chk.sv
module rtc_wcommit_chk #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int DELAY = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_i,
  input logic          busy,
  input logic          cmt,
  input logic [AW-1:0] c_addr,
  input logic [DW-1:0] c_data,
  input logic          inv_q,
  input logic          err_q,
  input logic          done_q,
  input logic          alm_q,
  input logic          run_q,
  input logic          seen,
  input logic [DW-1:0] sec,
  input logic [DW-1:0] frac,
  input logic [DW-1:0] almhi_q,
  input logic [DW-1:0] almlo_q,
  input logic [DW-1:0] status_w,
  input logic [DW-1:0] ien_q,
  input logic          irq_o
);
  import rtc_pkg::*;
  localparam int CW = $clog2(DELAY + 1) + 1;

  logic [CW-1:0] bcnt;
  logic          match, st_clr_alm, raw_irq;

  assign match      = (sec == almhi_q) && (frac == almlo_q) && !(&almhi_q);
  assign st_clr_alm = cmt && (c_addr == AW'(ADR_STAT)) && c_data[B_ALM];
  assign raw_irq    = |(status_w & ien_q & DW'(IRQ_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + CW'(1);
    else           bcnt <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < CW'(DELAY)));
  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == CW'(DELAY)));
  p_done_or_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_q || err_q || ((c_addr == AW'(ADR_STAT)) && c_data[B_DONE])));
  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt && inv_q && (c_addr != AW'(ADR_STAT))) |=> (err_q && !done_q));
  p_refuse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt && inv_q && (c_addr == AW'(ADR_CTRL))) |=> $stable(run_q));
  p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && busy) |=> err_q);
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !(cmt && (c_addr == AW'(ADR_FRAC)))) |=> $stable(frac));
  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmt) |=> ($stable(frac) && $stable(sec)));
  p_alarm_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !st_clr_alm) |=> alm_q);
  p_alarm_unset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((&almhi_q) && !alm_q) |=> !alm_q);
  p_irq_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
    raw_irq |=> irq_o);
  p_irq_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_irq |=> !irq_o);
endmodule

bind rtc_wcommit rtc_wcommit_chk #(.DW(DW), .AW(AW), .DELAY(DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .busy(busy), .cmt(cmt),
  .c_addr(c_addr), .c_data(c_data), .inv_q(inv_q), .err_q(err_q),
  .done_q(done_q), .alm_q(alm_q), .run_q(run_q), .seen(seen), .sec(sec),
  .frac(frac), .almhi_q(almhi_q), .almlo_q(almlo_q), .status_w(status_w),
  .ien_q(ien_q), .irq_o(irq_o)
);

// File: tb/tb_rtc_wcommit.sv
module tb_rtc_wcommit;
  localparam int DELAY = 4;

  logic        clk, rst_n, tick, wr, rd, irq;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  int checks, errors;
  bit done;

  rtc_wcommit #(.DW(32), .AW(3), .DELAY(DELAY)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    repeat (DELAY) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rreg(3'd5, d); chk("R1 status", d, 32'h202);
    rreg(3'd2, d); chk("R1 alarm upper", d, 32'hFFFF_FFFF);
    rreg(3'd0, d); chk("R1 seconds", d, 0);
    rreg(3'd4, d); chk("R1 control", d, 0);
    rd = 1'b0; addr = 3'd2; #1;
    chk("R1 rdata idle", rdata, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_refuse;
    logic [31:0] d;
    wreg(3'd4, 32'h8);
    rreg(3'd4, d); chk("R2 control unchanged", d, 0);
    rreg(3'd5, d); chk("R2 error set, no complete", d, 32'h282);
  endtask

  task automatic t_revalid;
    logic [31:0] d;
    wreg(3'd5, 32'h2);
    rreg(3'd5, d); chk("R3 one bit keeps not-valid", d, 32'h382);
    wreg(3'd5, 32'h83);
    rreg(3'd5, d); chk("R3 valid, error cleared", d, 32'h300);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    @(negedge clk);
    addr = 3'd6; wdata = 0; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    rreg(3'd5, d); chk("R4 busy after accept", d, 32'h400);
    repeat (3) @(negedge clk);
    rreg(3'd5, d); chk("R4 busy before commit", d, 32'h400);
    @(negedge clk);
    rreg(3'd5, d); chk("R4 done at 4th edge", d, 32'h300);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk);
    addr = 3'd6; wdata = 32'h100; wr = 1'b1;
    @(negedge clk);
    wdata = 32'h80;
    @(negedge clk);
    wr = 1'b0;
    rreg(3'd5, d); chk("R5 error on collision", d & 32'h80, 32'h80);
    repeat (3) @(negedge clk);
    rreg(3'd6, d); chk("R5 first write kept", d, 32'h100);
    rreg(3'd5, d); chk("R5 status after", d, 32'h380);
    wreg(3'd5, 32'h80);
    rreg(3'd5, d); chk("R3 error cleared by one", d, 32'h300);
    wreg(3'd6, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wreg(3'd4, 32'h8);
    ticks(3);
    rreg(3'd1, d); chk("R7 frozen before any write", d, 0);
    wreg(3'd1, 32'hFFFF_FFFE);
    ticks(2);
    rreg(3'd1, d); chk("R7 frozen after fraction write", d, 32'hFFFF_FFFE);
    wreg(3'd0, 32'd5);
    ticks(1);
    rreg(3'd1, d); chk("R6 fraction step", d, 32'hFFFF_FFFF);
    rreg(3'd0, d); chk("R6 seconds before wrap", d, 5);
    ticks(1);
    rreg(3'd1, d); chk("R6 fraction wrap", d, 0);
    rreg(3'd0, d); chk("R6 seconds carry", d, 6);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    wreg(3'd4, 32'h0);
    ticks(3);
    rreg(3'd1, d); chk("R8 fraction held", d, 0);
    rreg(3'd0, d); chk("R8 seconds held", d, 6);
    wreg(3'd4, 32'h8);
  endtask

  task automatic t_alarm;
    logic [31:0] d;
    wreg(3'd3, 32'd1);
    wreg(3'd6, 32'h10);
    wreg(3'd2, 32'd6);
    rreg(3'd5, d); chk("R9 no flag before match", d, 32'h300);
    ticks(1);
    repeat (2) @(negedge clk);
    rreg(3'd5, d); chk("R9 flag on match", d, 32'h310);
    chk("R11 irq from alarm", {31'd0, irq}, 1);
    ticks(1);
    rreg(3'd5, d); chk("R9 flag sticky", d, 32'h310);
    wreg(3'd5, 32'h10);
    rreg(3'd5, d); chk("R3 alarm flag cleared", d, 32'h300);
    @(negedge clk);
    chk("R11 irq drops", {31'd0, irq}, 0);
  endtask

  task automatic t_unset;
    logic [31:0] d;
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd3, 32'd0);
    wreg(3'd0, 32'hFFFF_FFFF);
    wreg(3'd1, 32'd0);
    repeat (3) @(negedge clk);
    rreg(3'd0, d); chk("R10 counter equals alarm", d, 32'hFFFF_FFFF);
    rreg(3'd5, d); chk("R10 no flag when unset", d, 32'h300);
  endtask

  task automatic t_irq_done;
    logic [31:0] d;
    wreg(3'd6, 32'h100);
    @(negedge clk);
    chk("R11 irq from write complete", {31'd0, irq}, 1);
    wreg(3'd5, 32'h100);
    rreg(3'd5, d); chk("R3 complete cleared by one", d, 32'h200);
    @(negedge clk);
    chk("R11 irq low after clear", {31'd0, irq}, 0);
    wreg(3'd6, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_refuse;
    t_revalid;
    t_latency;
    t_collide;
    t_count;
    t_halt;
    t_alarm;
    t_unset;
    t_irq_done;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got 0x%08h expected 0x%08h", 32'd0, 32'd1);
    finish_run;
  end
endmodule